// File: doc/BRIEF.md
# Ping-Pong Buffered 7:1 DDR Serializer

This block turns a stream of 28-bit parallel words into four serial lanes that each carry seven bits per word period. Words arrive on a slow word clock. The bits leave on a fast clock that runs at 3.5 times the word rate, with two bits sent per fast cycle, one in each half of the cycle. The two clocks are phase locked. Every second word-clock rising edge lands on a fast rising edge. The other word-clock rising edges land on fast falling edges.

The two domains are joined by a two-entry ping-pong buffer. The word side writes each new word into the two slots in turn. The fast side reads only a slot whose contents are settled. A seven-state read sequencer covers two word periods. In each fast cycle it picks one bit pair per lane. In the middle state, the pair spans the end of one word and the start of the next. A one-cycle pulse on `alignMark` identifies the fast edge that coincides with a word-clock edge, and the sequencer restarts from that edge. The final output stage is a behavioural DDR register: it shows the rising-edge bit while the fast clock is high and the falling-edge bit while it is low.

Top module: `ddrSerializer`

## Requirements
- R1: Each rising edge of `wordClk` stores `wordData` into one of two slots, alternating between them. The first edge after reset writes slot 0, so words with an even count land in slot 0 and words with an odd count land in slot 1.
- R2: While `rstN` is low, both slots, both pair outputs and `serOut` are all zero.
- R3: When `alignMark` is high at a fast rising edge, that edge is sequencer state 0. Each following fast edge advances the state by one, modulo 7.
- R4: Until the first `alignMark`, `pairRise` and `pairFall` hold zero.
- R5: Lane L carries word bits [7L+6:7L], most significant bit first.
- R6: At state k, each lane's rising bit is position 2k and its falling bit is position 2k+1 of a 14-bit stream. Positions 0 to 6 come from slot 1, the earlier word. Positions 7 to 13 come from slot 0, the later word. The selected pair appears on `pairRise`/`pairFall` after that fast edge.
- R7: At state 3, the rising bit is the last bit (bit 7L) of the earlier word and the falling bit is the first bit (bit 7L+6) of the later word.
- R8: States 0 to 2 take both bits from slot 1 only, and states 4 to 6 take both bits from slot 0 only. No slot is read at an edge where it is written.
- R9: `serOut` shows the previous cycle's `pairRise` during the high half of each fast cycle and the previous cycle's `pairFall` during the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fastClk | input | 1 | Bit clock, 3.5 times the word rate |
| wordClk | input | 1 | Word-rate clock, phase locked to fastClk |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wordData | input | 28 | Parallel word, captured on the rising edge of wordClk |
| alignMark | input | 1 | High for the fast cycle whose rising edge coincides with a wordClk rise |
| pairRise | output | 4 | Registered first-half bit, one per lane |
| pairFall | output | 4 | Registered second-half bit, one per lane |
| serOut | output | 4 | Double-rate serial lane outputs |

## Verification
The assertions and the slot-to-state mapping take three things for granted about the inputs. First, `alignMark` pulses every seventh fast edge. Second, the first `wordClk` rise after reset falls on the first marked edge, so slot 0 is always the slot written at state 0. Third, later word edges arrive every 3.5 fast cycles. The stimulus releases reset with the word clock held idle. It starts the word clock on exactly the first marked fast edge and then toggles it every 8.75 ns against the 5 ns bit clock, so the phase relation never drifts. Because data changes only on word-clock falling edges, every write is away from the fast edges that read it.

// File: rtl/serPkg.sv
`timescale 1ns/1ps
package serPkg;
  // Width of the sequencer state carried between control and datapath.
  localparam int unsigned SEQ_PHASE_W = 4;

  // Strobes from the read sequencer to the datapath.
  typedef struct packed {
    logic                   capture;   // load the pair registers this edge
    logic [SEQ_PHASE_W-1:0] phase;     // sequencer state for this edge
  } seqStrobe_t;
endpackage

// File: rtl/serCtrl.sv
`timescale 1ns/1ps
module serCtrl
  import serPkg::*;
#(
  parameter int unsigned BITS = 7
) (
  input  logic       fastClk,
  input  logic       rstN,
  input  logic       alignMark,
  output seqStrobe_t strobe
);
  localparam logic [SEQ_PHASE_W-1:0] LAST = SEQ_PHASE_W'(BITS - 1);

  logic [SEQ_PHASE_W-1:0] phaseQ;
  logic [SEQ_PHASE_W-1:0] effPhase;
  logic                   runQ;

  // The marker forces state 0 on the edge it coincides with.
  always_comb begin
    effPhase       = alignMark ? '0 : phaseQ;
    strobe.capture = runQ | alignMark;
    strobe.phase   = effPhase;
  end

  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= '0;
      runQ   <= 1'b0;
    end else if (alignMark || runQ) begin
      runQ   <= 1'b1;
      phaseQ <= (effPhase == LAST) ? '0 : effPhase + SEQ_PHASE_W'(1);
    end
  end

  AST_ALIGN_RESTART: assert property (@(posedge fastClk) disable iff (!rstN)
    alignMark |=> phaseQ == SEQ_PHASE_W'(1)); // R3
  AST_PHASE_RANGE: assert property (@(posedge fastClk) disable iff (!rstN)
    phaseQ <= LAST); // R3
  AST_IDLE_PHASE: assert property (@(posedge fastClk) disable iff (!rstN)
    !runQ && !alignMark |=> !runQ && phaseQ == '0); // R4
endmodule

// File: rtl/slotBank.sv
`timescale 1ns/1ps
module slotBank #(
  parameter int unsigned WORD_W = 28
) (
  input  logic              wordClk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] wordData,
  output logic [WORD_W-1:0] slotEarly,
  output logic [WORD_W-1:0] slotLate
);
  localparam int unsigned SLOTS = 2;

  logic writeSel;

  always_ff @(posedge wordClk or negedge rstN) begin
    if (!rstN) writeSel <= 1'b0;
    else       writeSel <= ~writeSel;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : gSlot
    logic [WORD_W-1:0] slotQ;
    always_ff @(posedge wordClk or negedge rstN) begin
      if (!rstN)                  slotQ <= '0;
      else if (writeSel == 1'(s)) slotQ <= wordData;
    end
  end

  // Slot 0 holds the later word of a pair, slot 1 the earlier one.
  assign slotLate  = gSlot[0].slotQ;
  assign slotEarly = gSlot[1].slotQ;

  AST_SLOT_TOGGLE: assert property (@(posedge wordClk) disable iff (!rstN)
    writeSel |=> !writeSel); // R1
  AST_IDLE_SLOT_STABLE: assert property (@(posedge wordClk) disable iff (!rstN)
    writeSel |=> $stable(slotLate)); // R1
endmodule

// File: rtl/ddrLane.sv
`timescale 1ns/1ps
module ddrLane (
  input  logic fastClk,
  input  logic rstN,
  input  logic riseBit,
  input  logic fallBit,
  output logic serBit
);
  logic posQ;
  logic negQ;
  logic fallHold;

  // Both bits are taken on the rising edge. The two-flop XOR pair shows
  // posQ^negQ, which equals riseBit after a rising edge and fallHold after
  // a falling edge.
  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN) begin
      posQ     <= 1'b0;
      fallHold <= 1'b0;
    end else begin
      posQ     <= riseBit ^ negQ;
      fallHold <= fallBit;
    end
  end

  always_ff @(negedge fastClk or negedge rstN) begin
    if (!rstN) negQ <= 1'b0;
    else       negQ <= fallHold ^ posQ;
  end

  assign serBit = posQ ^ negQ;

  AST_DDR_LOW_HALF: assert property (@(posedge fastClk) disable iff (!rstN)
    1'b1 |=> serBit == $past(fallBit)); // R9
endmodule

// File: rtl/serDatapath.sv
`timescale 1ns/1ps
module serDatapath
  import serPkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned BITS  = 7
) (
  input  logic                    fastClk,
  input  logic                    wordClk,
  input  logic                    rstN,
  input  logic [LANES*BITS-1:0]   wordData,
  input  seqStrobe_t              strobe,
  output logic [LANES-1:0]        pairRise,
  output logic [LANES-1:0]        pairFall,
  output logic [LANES-1:0]        serOut
);
  localparam int unsigned WORD_W = LANES * BITS;
  localparam int unsigned MID    = (BITS - 1) / 2;

  logic [WORD_W-1:0] slotEarly;
  logic [WORD_W-1:0] slotLate;
  logic [LANES-1:0]  riseNext;
  logic [LANES-1:0]  fallNext;

  slotBank #(.WORD_W(WORD_W)) uSlots (
    .wordClk  (wordClk),
    .rstN     (rstN),
    .wordData (wordData),
    .slotEarly(slotEarly),
    .slotLate (slotLate)
  );

  // Position pos of the two-word stream for one lane, MSB first.
  function automatic logic pickBit(input logic [WORD_W-1:0] early,
                                   input logic [WORD_W-1:0] late,
                                   input int ln, input int pos);
    if (pos < int'(BITS)) return early[ln*int'(BITS) + int'(BITS) - 1 - pos];
    else                  return late[ln*int'(BITS) + 2*int'(BITS) - 1 - pos];
  endfunction

  always_comb begin
    riseNext = '0;
    fallNext = '0;
    for (int ln = 0; ln < int'(LANES); ln++) begin
      riseNext[ln] = pickBit(slotEarly, slotLate, ln, 2*int'(strobe.phase));
      fallNext[ln] = pickBit(slotEarly, slotLate, ln, 2*int'(strobe.phase) + 1);
    end
  end

  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN) begin
      pairRise <= '0;
      pairFall <= '0;
    end else if (strobe.capture) begin
      pairRise <= riseNext;
      pairFall <= fallNext;
    end
  end

  for (genvar ln = 0; ln < LANES; ln++) begin : gLane
    ddrLane uDdr (
      .fastClk(fastClk),
      .rstN   (rstN),
      .riseBit(pairRise[ln]),
      .fallBit(pairFall[ln]),
      .serBit (serOut[ln])
    );
  end

  AST_IDLE_HOLD: assert property (@(posedge fastClk) disable iff (!rstN)
    !strobe.capture |=> $stable(pairRise) && $stable(pairFall)); // R4
  AST_STRADDLE: assert property (@(posedge fastClk) disable iff (!rstN)
    strobe.capture && strobe.phase == SEQ_PHASE_W'(MID) |=>
      pairRise[0] == $past(slotEarly[0]) && pairFall[0] == $past(slotLate[BITS-1])); // R7
endmodule

// File: rtl/ddrSerializer.sv
`timescale 1ns/1ps
module ddrSerializer
  import serPkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned BITS  = 7
) (
  input  logic                  fastClk,
  input  logic                  wordClk,
  input  logic                  rstN,
  input  logic [LANES*BITS-1:0] wordData,
  input  logic                  alignMark,
  output logic [LANES-1:0]      pairRise,
  output logic [LANES-1:0]      pairFall,
  output logic [LANES-1:0]      serOut
);
  seqStrobe_t strobe;

  serCtrl #(.BITS(BITS)) uCtrl (
    .fastClk  (fastClk),
    .rstN     (rstN),
    .alignMark(alignMark),
    .strobe   (strobe)
  );

  serDatapath #(.LANES(LANES), .BITS(BITS)) uPath (
    .fastClk (fastClk),
    .wordClk (wordClk),
    .rstN    (rstN),
    .wordData(wordData),
    .strobe  (strobe),
    .pairRise(pairRise),
    .pairFall(pairFall),
    .serOut  (serOut)
  );
endmodule

// File: tb/sim_ddrSerializer.sv
`timescale 1ns/1ps
module sim_ddrSerializer;
  localparam int LANES  = 4;
  localparam int BITS   = 7;
  localparam int GROUPS = 80;

  logic              fastClk = 1'b0;
  logic              wordClk = 1'b0;
  logic              rstN = 1'b0;
  logic              alignMark = 1'b0;
  logic [27:0]       wordData;
  logic [LANES-1:0]  pairRise, pairFall, serOut;

  int checks = 0;
  int fails = 0;
  int edgeIdx = -1;
  bit done = 1'b0;

  ddrSerializer u0 (
    .fastClk(fastClk), .wordClk(wordClk), .rstN(rstN), .wordData(wordData),
    .alignMark(alignMark), .pairRise(pairRise), .pairFall(pairFall), .serOut(serOut)
  );

  always #2.5 fastClk = ~fastClk;  // 200 MHz

  function automatic logic [27:0] wordVal(int j);
    logic [31:0] h;
    case (j)
      0: return 28'hFFFFFFF;
      1: return 28'h0000000;
      2: return 28'hAAAAAAA;
      3: return 28'h5555555;
      4: return 28'h8102040;   // only each lane's MSB set
      5: return 28'h0204081;   // only each lane's LSB set
      default: begin
        h = 32'(j) * 32'h9E3779B1 ^ (32'(j) << 13);
        return h[31:4];
      end
    endcase
  endfunction

  // Expected lane bits for pair edge idx (half 0 = rising, 1 = falling).
  // Word j is written at the j-th word edge, counting from the first marked edge.
  function automatic logic [3:0] expBits(int idx, int half);
    logic [3:0]  r;
    logic [27:0] w;
    int k, g, pos;
    r = '0;
    if (idx < 0) return r;
    k = idx % BITS;
    g = idx / BITS;
    pos = 2*k + half;
    for (int ln = 0; ln < LANES; ln++) begin
      if (pos < BITS) begin
        w = (g == 0) ? 28'h0 : wordVal(2*g - 1);   // R1: earlier word in slot 1
        r[ln] = w[ln*BITS + BITS - 1 - pos];        // R5: MSB first
      end else begin
        w = wordVal(2*g);
        r[ln] = w[ln*BITS + 2*BITS - 1 - pos];
      end
    end
    return r;
  endfunction

  function automatic string pairTag(int idx);
    if (idx < 0) return "R4";
    if (idx % BITS == 3) return "R7";
    if (idx % BITS < 3) return "R8";
    return "R6";
  endfunction

  task automatic checkVal(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic reportEnd();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Bench edge counter: R3, state 0 is the marked edge.
  always @(posedge fastClk) begin
    if (rstN) begin
      if (edgeIdx >= 0) edgeIdx++;
      else if (alignMark) edgeIdx = 0;
    end
  end

  // Early in the high half: pair registers (R6/R7/R8/R4) and rising serial bit (R9).
  always @(posedge fastClk) begin
    if (rstN && !done) begin
      #1.25;
      checkVal({pairTag(edgeIdx), " rise"}, pairRise, expBits(edgeIdx, 0));
      checkVal({pairTag(edgeIdx), " fall"}, pairFall, expBits(edgeIdx, 1));
      checkVal("R9 high half", serOut, expBits(edgeIdx - 1, 0));
    end
  end

  // Early in the low half: falling serial bit (R9).
  always @(negedge fastClk) begin
    if (rstN && !done) begin
      #1.25;
      checkVal("R9 low half", serOut, expBits(edgeIdx - 1, 1));
    end
  end

  // Word clock starts exactly on the first marked fast edge.
  initial begin
    int j;
    j = 0;
    wordData = wordVal(0);
    wait (rstN);
    @(posedge fastClk iff alignMark);
    forever begin
      wordClk = 1'b1;
      #8.75;
      wordClk = 1'b0;
      j++;
      wordData = wordVal(j);
      #8.75;
    end
  end

  initial begin
    repeat (3) @(negedge fastClk);
    checkVal("R2 pairRise", pairRise, 4'h0);
    checkVal("R2 pairFall", pairFall, 4'h0);
    checkVal("R2 serOut", serOut, 4'h0);
    rstN = 1'b1;
    repeat (6) @(negedge fastClk);   // idle: R4 checks run
    alignMark = 1'b1;
    @(negedge fastClk);
    alignMark = 1'b0;
    for (int g = 1; g < GROUPS; g++) begin
      repeat (6) @(negedge fastClk);
      alignMark = 1'b1;
      @(negedge fastClk);
      alignMark = 1'b0;
    end
    repeat (8) @(negedge fastClk);
    done = 1'b1;
    #10;
    reportEnd();
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      reportEnd();
    end
  end
endmodule